// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether a port I/O access may proceed, by consulting the permission bitmap stored in the current task state segment. A request gives the 16-bit port number, the access width in bytes (1, 2 or 4), and the task register's base address, limit and attribute flags. The block first checks that the task register describes a usable 32-bit task segment. It then reads a halfword from memory that gives the bitmap's start offset. Next it checks that two bitmap bytes fit inside the segment, reads them as one halfword, and tests the bits that cover the accessed ports.

The result is either an allow or a general-protection fault. The fault always carries error code zero. The block talks to memory through a simple request/acknowledge port that returns 16-bit little-endian halfwords. A single-cycle `start` launches a check, and a single-cycle `done` ends it. When the port number comes from a wider register, the caller passes only its low 16 bits.

Top module: `io_perm_check`

## Requirements
- R1: The task register counts as usable only when `trFlags` bit 7 (present) is 1, `trFlags` bits 3:0 equal 9, and `trLimit` is at least 103. Otherwise the check ends with `fault` set and no memory request is issued.
- R2: For a usable task register, the first memory read is the halfword at `trBase + 0x66`. Its value is the bitmap start offset.
- R3: The bitmap byte offset is the start offset plus `portAddr >> 3`, computed without wrap at 16 bits. The second read is the halfword at `trBase` plus that offset. The byte at the lower address lands in bits 7:0.
- R4: If the bitmap byte offset plus 1 is greater than `trLimit`, the check faults after the first read and the second read is skipped. An offset plus 1 equal to the limit is in bounds.
- R5: The second halfword is shifted right by `portAddr[2:0]`. The access is allowed only if the low `accSize` bits of the result are all zero. Otherwise it faults. Bits that come from the second byte count too.
- R6: `errCode` is always zero, including whenever `fault` is reported.
- R7: `done` is high for exactly one cycle per check, and in that cycle exactly one of `allow` and `fault` is set. Both values stay unchanged until the next `start`.
- R8: Once `memReq` is raised, it stays high with `memAddr` stable until `memAck` is seen.
- R9: Every 16-bit port number is handled, including ports at the top of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a check |
| portAddr | input | 16 | Port number of the access |
| accSize | input | 3 | Access width in bytes: 1, 2 or 4 |
| trBase | input | ADDR_W | Task segment base address |
| trLimit | input | LIMIT_W | Task segment limit |
| trFlags | input | 8 | Task register attributes: bit 7 present, bits 3:0 type |
| memReq | output | 1 | Halfword read request |
| memAddr | output | ADDR_W | Byte address of the halfword to read |
| memAck | input | 1 | Read acknowledge; data valid with it |
| memRdata | input | 16 | Read halfword, lower address in bits 7:0 |
| done | output | 1 | One-cycle end-of-check pulse |
| allow | output | 1 | Access permitted |
| fault | output | 1 | General-protection fault |
| errCode | output | 16 | Fault error code (always zero) |

## Verification
The assertions assume that the task register inputs stay unchanged from `start` until `done`. The usable-register property compares live port values against the memory requests, and would fail without this. They also assume that `memAck` comes only while a request is pending and that `start` is pulsed only while the block is idle. The bench keeps to all three assumptions. It changes inputs only between checks and waits for `done` before the next `start`. Its memory model acknowledges one cycle after each request. The model returns bitmap contents computed from the address, so any port and offset can be checked arithmetically.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PTR,
    ST_BOUND,
    ST_MAP,
    ST_TEST,
    ST_DONE
  } chkState_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadReq;  // capture request inputs
    logic selMap;   // address the bitmap word instead of the offset word
    logic capPtr;   // capture bitmap start offset
    logic capMap;   // capture bitmap halfword
  } dpCtrl_t;

endpackage

// File: rtl/ioperm_dp.sv
module ioperm_dp
  import ioperm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LIMIT_W   = 32,
  parameter int PTR_OFS   = 'h66,
  parameter int MIN_LIMIT = 103,
  parameter int TSS_TYPE  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [15:0]        portAddr,
  input  logic [2:0]         accSize,
  input  logic [ADDR_W-1:0]  trBase,
  input  logic [LIMIT_W-1:0] trLimit,
  input  logic [7:0]         trFlags,
  input  logic [15:0]        memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               trOk,
  output logic               inBounds,
  output logic               bitsClear
);

  localparam int OFS_W  = 17;
  localparam int WORD_W = 16;
  localparam int CMP_W  = LIMIT_W + 1;

  logic [15:0]        portR;
  logic [2:0]         sizeR;
  logic [ADDR_W-1:0]  baseR;
  logic [LIMIT_W-1:0] limitR;
  logic [7:0]         flagsR;
  logic [15:0]        ptrR;
  logic [WORD_W-1:0]  wordR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portR  <= '0;
      sizeR  <= '0;
      baseR  <= '0;
      limitR <= '0;
      flagsR <= '0;
      ptrR   <= '0;
      wordR  <= '0;
    end else begin
      if (ctrl.loadReq) begin
        portR  <= portAddr;
        sizeR  <= accSize;
        baseR  <= trBase;
        limitR <= trLimit;
        flagsR <= trFlags;
      end
      if (ctrl.capPtr) ptrR  <= memRdata;
      if (ctrl.capMap) wordR <= memRdata;
    end
  end

  // Task register usability
  assign trOk = flagsR[7] && (flagsR[3:0] == 4'(TSS_TYPE)) &&
                (limitR >= LIMIT_W'(MIN_LIMIT));

  // Bitmap byte offset and bounds (two bytes must fit)
  logic [OFS_W-1:0] mapOfs;
  logic [CMP_W-1:0] endOfs;
  assign mapOfs   = {1'b0, ptrR} + OFS_W'(portR[15:3]);
  assign endOfs   = CMP_W'(mapOfs) + CMP_W'(1);
  assign inBounds = endOfs <= {1'b0, limitR};

  assign memAddr = baseR + (ctrl.selMap ? ADDR_W'(mapOfs) : ADDR_W'(PTR_OFS));

  // Bit test: mask of sizeR ones over the shifted word
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] sizeMask;
  assign shifted = wordR >> portR[2:0];

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign sizeMask[i] = (i < int'(sizeR));
  end

  assign bitsClear = (shifted & sizeMask) == '0;

endmodule

// File: rtl/ioperm_ctrl.sv
module ioperm_ctrl
  import ioperm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    trOk,
  input  logic    inBounds,
  input  logic    bitsClear,
  input  logic    memAck,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    done,
  output logic    allow,
  output logic    fault
);

  chkState_e state, stateNxt;
  logic setAllow, setFault;
  logic allowR, faultR;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    memReq   = 1'b0;
    setAllow = 1'b0;
    setFault = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadReq = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (trOk) begin
          stateNxt = ST_PTR;
        end else begin
          setFault = 1'b1;
          stateNxt = ST_DONE;
        end
      end
      ST_PTR: begin
        memReq = 1'b1;
        if (memAck) begin
          ctrl.capPtr = 1'b1;
          stateNxt    = ST_BOUND;
        end
      end
      ST_BOUND: begin
        if (inBounds) begin
          stateNxt = ST_MAP;
        end else begin
          setFault = 1'b1;
          stateNxt = ST_DONE;
        end
      end
      ST_MAP: begin
        memReq      = 1'b1;
        ctrl.selMap = 1'b1;
        if (memAck) begin
          ctrl.capMap = 1'b1;
          stateNxt    = ST_TEST;
        end
      end
      ST_TEST: begin
        setAllow = bitsClear;
        setFault = !bitsClear;
        stateNxt = ST_DONE;
      end
      ST_DONE: begin
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      allowR <= 1'b0;
      faultR <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctrl.loadReq) begin
        allowR <= 1'b0;
        faultR <= 1'b0;
      end else if (setAllow || setFault) begin
        allowR <= setAllow;
        faultR <= setFault;
      end
    end
  end

  assign done  = (state == ST_DONE);
  assign allow = allowR;
  assign fault = faultR;

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import ioperm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LIMIT_W   = 32,
  parameter int PTR_OFS   = 'h66,
  parameter int MIN_LIMIT = 103,
  parameter int TSS_TYPE  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [15:0]        portAddr,
  input  logic [2:0]         accSize,
  input  logic [ADDR_W-1:0]  trBase,
  input  logic [LIMIT_W-1:0] trLimit,
  input  logic [7:0]         trFlags,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memAck,
  input  logic [15:0]        memRdata,
  output logic               done,
  output logic               allow,
  output logic               fault,
  output logic [15:0]        errCode
);

  dpCtrl_t ctrl;
  logic trOk, inBounds, bitsClear;

  ioperm_dp #(
    .ADDR_W   (ADDR_W),
    .LIMIT_W  (LIMIT_W),
    .PTR_OFS  (PTR_OFS),
    .MIN_LIMIT(MIN_LIMIT),
    .TSS_TYPE (TSS_TYPE)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .portAddr (portAddr),
    .accSize  (accSize),
    .trBase   (trBase),
    .trLimit  (trLimit),
    .trFlags  (trFlags),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .trOk     (trOk),
    .inBounds (inBounds),
    .bitsClear(bitsClear)
  );

  ioperm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .trOk     (trOk),
    .inBounds (inBounds),
    .bitsClear(bitsClear),
    .memAck   (memAck),
    .ctrl     (ctrl),
    .memReq   (memReq),
    .done     (done),
    .allow    (allow),
    .fault    (fault)
  );

  // Every fault raised here is a general-protection fault with code zero
  assign errCode = '0;

endmodule

// File: rtl/ioperm_chk.sv
module ioperm_chk #(
  parameter int ADDR_W    = 32,
  parameter int LIMIT_W   = 32,
  parameter int MIN_LIMIT = 103,
  parameter int TSS_TYPE  = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic [LIMIT_W-1:0] trLimit,
  input logic [7:0]         trFlags,
  input logic               memReq,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               memAck,
  input logic               done,
  input logic               allow,
  input logic               fault
);

  logic trUsable;
  assign trUsable = trFlags[7] && (trFlags[3:0] == 4'(TSS_TYPE)) &&
                    (trLimit >= LIMIT_W'(MIN_LIMIT));

  // R1
  read_needs_tr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> trUsable);

  // R1
  bad_tr_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !trUsable) |-> fault);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (allow != fault));

  // R7
  no_read_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

endmodule

bind io_perm_check ioperm_chk #(
  .ADDR_W   (ADDR_W),
  .LIMIT_W  (LIMIT_W),
  .MIN_LIMIT(MIN_LIMIT),
  .TSS_TYPE (TSS_TYPE)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .trLimit(trLimit),
  .trFlags(trFlags),
  .memReq (memReq),
  .memAddr(memAddr),
  .memAck (memAck),
  .done   (done),
  .allow  (allow),
  .fault  (fault)
);

// File: tb/tb_io_perm_check.sv
`timescale 1ns/1ps
module tb_io_perm_check;

  localparam int ADDR_W  = 32;
  localparam int LIMIT_W = 32;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [15:0]        portAddr = '0;
  logic [2:0]         accSize = 3'd1;
  logic [ADDR_W-1:0]  trBase = BASE;
  logic [LIMIT_W-1:0] trLimit = '0;
  logic [7:0]         trFlags = '0;
  logic               memReq;
  logic [ADDR_W-1:0]  memAddr;
  logic               memAck;
  logic [15:0]        memRdata;
  logic               done, allow, fault;
  logic [15:0]        errCode;

  int checks = 0;
  int errors = 0;
  logic [15:0] curPtr = 16'h0068;

  always #2.5 clk = ~clk;

  io_perm_check dut (
    .clk(clk), .rstN(rstN), .start(start), .portAddr(portAddr),
    .accSize(accSize), .trBase(trBase), .trLimit(trLimit), .trFlags(trFlags),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .done(done), .allow(allow), .fault(fault), .errCode(errCode)
  );

  // Bitmap byte content as a function of segment offset
  function automatic logic [7:0] patByte(input logic [31:0] ofs);
    logic [31:0] t;
    t = ofs * 32'd37 + 32'd11;
    return (ofs[1:0] == 2'b00) ? 8'h00 : (t[7:0] & 8'h93);
  endfunction

  function automatic logic [7:0] memByte(input logic [31:0] addr);
    logic [31:0] ofs;
    ofs = addr - BASE;
    if (ofs == 32'h66) return curPtr[7:0];
    if (ofs == 32'h67) return curPtr[15:8];
    return patByte(ofs);
  endfunction

  // Memory model: acknowledge one cycle after a request
  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck   <= memReq && !memAck;
      memRdata <= {memByte(memAddr + 32'd1), memByte(memAddr)};
    end
  end

  // Handshake log
  int hsCnt = 0;
  logic [31:0] lastAddr = '0, prevAddr = '0;
  always @(posedge clk) begin
    if (memReq && memAck) begin
      prevAddr <= lastAddr;
      lastAddr <= memAddr;
      hsCnt    <= hsCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s port=%04h size=%0d act=%0h exp=%0h",
               req, what, portAddr, accSize, act, exp);
    end
  endtask

  task automatic runAccess(input logic [15:0] port, input logic [2:0] size,
                           input logic [7:0] flags, input logic [31:0] limit,
                           input logic [15:0] ptr);
    bit expValid, expAllow;
    int expN, n0, waitCnt;
    logic [16:0] ofs;
    logic [15:0] word, sh, mask;
    @(negedge clk);
    portAddr = port; accSize = size; trFlags = flags; trLimit = limit;
    curPtr = ptr;
    n0 = hsCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      check(1'b0, "R7", "timeout", 0, 1);
      return;
    end
    // expected values
    expValid = flags[7] && (flags[3:0] == 4'd9) && (limit >= 32'd103);
    ofs = {1'b0, ptr} + 17'(port[15:3]);
    expAllow = 1'b0;
    if (!expValid) expN = 0;
    else if ({15'd0, ofs} + 32'd1 > limit) expN = 1;
    else begin
      expN = 2;
      word = {patByte({15'd0, ofs} + 32'd1), patByte({15'd0, ofs})};
      sh = word >> port[2:0];
      mask = 16'((32'd1 << size) - 32'd1);
      expAllow = (sh & mask) == 16'd0;
    end
    if (!expValid)
      check(hsCnt - n0 == 0, "R1", "reads", hsCnt - n0, 0);
    else if (expN == 1)
      check(hsCnt - n0 == 1, "R4", "reads", hsCnt - n0, 1);
    else
      check(hsCnt - n0 == 2, "R3", "reads", hsCnt - n0, 2);
    if (expN == 1)
      check(lastAddr == BASE + 32'h66, "R2", "ptrAddr", lastAddr, BASE + 32'h66);
    if (expN == 2) begin
      check(prevAddr == BASE + 32'h66, "R2", "ptrAddr", prevAddr, BASE + 32'h66);
      check(lastAddr == BASE + {15'd0, ofs}, "R3", "mapAddr", lastAddr,
            BASE + {15'd0, ofs});
    end
    check(allow == expAllow, expN == 2 ? "R5" : (expN == 1 ? "R4" : "R1"),
          "allow", allow, expAllow);
    check(fault == !expAllow, expN == 2 ? "R5" : (expN == 1 ? "R4" : "R1"),
          "fault", fault, !expAllow);
    check(errCode == 16'd0, "R6", "errCode", errCode, 0);
    @(negedge clk);
    check(!done, "R7", "donePulse", done, 0);
    check(allow == expAllow && fault == !expAllow, "R7", "hold",
          {allow, fault}, {expAllow, !expAllow});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    check(!done && !memReq && !allow && !fault, "R7", "reset",
          {done, memReq, allow, fault}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 R4: sweep ports and sizes, bitmap of 16 bytes (limit at boundary)
    for (int p = 0; p < 160; p++) begin
      for (int s = 0; s < 3; s++) begin
        runAccess(16'(p), 3'(1 << s), 8'h89, 32'h0000_0078, 16'h0068);
      end
    end

    // R1: unusable task register variants
    runAccess(16'h0010, 3'd1, 8'h09, 32'h0000_1000, 16'h0068);
    runAccess(16'h0010, 3'd2, 8'h8B, 32'h0000_1000, 16'h0068);
    runAccess(16'h0010, 3'd4, 8'h81, 32'h0000_1000, 16'h0068);
    runAccess(16'h0010, 3'd1, 8'h89, 32'd102, 16'h0068);
    // R4: minimum limit, bitmap immediately out of range
    runAccess(16'h0000, 3'd1, 8'h89, 32'd103, 16'h0068);

    // R9: top of the port range
    for (int p = 16'hFFE0; p <= 16'hFFFF; p++) begin
      runAccess(16'(p), 3'd4, 8'h89, 32'h0000_3000, 16'h1000);
      runAccess(16'(p), 3'd1, 8'h89, 32'h0000_3000, 16'h1000);
    end
    // R9 R3: offset carries past 16 bits
    runAccess(16'hFFFF, 3'd1, 8'h89, 32'h000F_FFFF, 16'hFFF0);
    runAccess(16'hFFF9, 3'd2, 8'h89, 32'h000F_FFFF, 16'hFFF0);
    // R4: one past the boundary with high ports
    runAccess(16'hFFFF, 3'd1, 8'h89, 32'h0000_2FFF, 16'h1000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule